// File: doc/BRIEF.md
# Software-Walked Translation Buffer with Miss-Handler Registers

This block is a small fully associative data translation buffer paired with the special registers that a software miss handler uses to refill it. A lookup port takes an effective address. In the same cycle it returns either a hit with the physical address and page attributes, or a miss flag. The hardware does not walk any page table itself.

On a miss, the block latches the faulting page and picks a victim slot with a round-robin pointer. Handler code then reads a level-one table pointer, loads the level-one entry from memory and writes it back into a control register. It reads the resulting level-two pointer, loads the leaf entry and writes it to the real-page register, which commits the translation. A scratch register lets the handler park a general register without side effects.

Addresses are 32 bits with 4 KB pages. Bits 31:22 index the first table level and bits 21:12 index the second. Table pointers are word aligned.

Top module: `tw_tlb_assist`

## Requirements
- R1: A lookup with `lk_valid` high that matches a valid entry asserts `lk_hit` combinationally in the same cycle. It drives `lk_paddr` = {entry real page, `lk_vaddr[11:0]`} and `lk_attr` = the entry's 12 attribute bits. On a miss both outputs are zero.
- R2: `lk_miss` is high exactly when `lk_valid` is high and no valid entry matches `lk_vaddr[31:12]`. `lk_hit` and `lk_miss` are never high together, and both are low while `lk_valid` is low.
- R3: A miss taken while no refill is pending is captured at the next clock edge. Register select 0 (miss page) then reads {missed address bits 31:12, 12'h001}.
- R4: The replacement pointer is cleared by reset and advances by one only when a miss is captured, wrapping from 7 to 0. The captured victim slot reads back in bits 2:0 of select 1 (control). The first capture after reset picks slot 0, the next slot 1, and so on.
- R5: From a capture until the real-page write, further misses still raise `lk_miss`, but the miss page and victim index stay unchanged.
- R6: A write to select 2 stores the level-one table base from data bits 31:12. A read of select 2 returns {base, missed address bits 31:22, 2'b00}.
- R7: A write to select 3 stores the level-two base from bits 31:12 and the level-one attributes from bits 11:0. The attributes read back in bits 27:16 of select 1. A read of select 3 returns {level-two base, missed address bits 21:12, 2'b00}.
- R8: A write to select 4 loads the victim slot with the latched miss page, real page = data bits 31:12, attributes = data bits 11:0, and marks it valid. It also ends the pending refill. The new entry hits from the next cycle.
- R9: Select 5 is a 32-bit scratch register that reads back what was written and affects nothing else.
- R10: Reset invalidates every entry and clears the replacement pointer and victim index.
- R11: Writes to selects 0, 1, 6 and 7 are ignored, and reads of selects 4, 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Effective address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No valid entry matches |
| lk_paddr | output | 32 | Physical address on hit, else zero |
| lk_attr | output | 12 | Page attributes on hit, else zero |
| sr_we | input | 1 | Special-register write strobe |
| sr_sel | input | 3 | Special-register select |
| sr_wdata | input | 32 | Special-register write data |
| sr_rdata | output | 32 | Special-register read data (combinational) |

## Verification
Lookup results and register read data are combinational, so the bench samples them 1 ns after driving inputs on the falling edge, before the next rising edge. A captured miss, a register write and a committed entry each take effect at the first rising edge after the stimulus. The bench therefore reads the affected register, or repeats the lookup, only from the following falling edge. The lock test issues a second miss while a refill is pending and reads the miss page and index before committing, so a lost lock shows up at the ports.

// File: rtl/tw_tlb_pkg.sv
package tw_tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_W   = 12;
    localparam int L1_W   = 10;
    localparam int L2_W   = 10;
    localparam int VPN_W  = VA_W - PG_W;
    localparam int ATTR_W = PG_W;

    localparam logic [ATTR_W-1:0] MISS_ATTR = 12'h001;

    typedef enum logic [2:0] {
        SEL_MPAGE = 3'd0,
        SEL_CTRL  = 3'd1,
        SEL_L1PTR = 3'd2,
        SEL_L2PTR = 3'd3,
        SEL_RPAGE = 3'd4,
        SEL_SCR   = 3'd5
    } sel_e;
endpackage

// File: rtl/tw_tlb_cam.sv
module tw_tlb_cam
    import tw_tlb_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int IW    = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [VPN_W-1:0]  wr_rpn,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              m_hit,
    output logic [VPN_W-1:0]  m_rpn,
    output logic [ATTR_W-1:0] m_attr
);
    typedef struct packed {
        logic              vld;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  rpn;
        logic [ATTR_W-1:0] attr;
    } ent_t;

    ent_t [N_ENT-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_en) begin
            ent_d[wr_idx].vld  = 1'b1;
            ent_d[wr_idx].vpn  = wr_vpn;
            ent_d[wr_idx].rpn  = wr_rpn;
            ent_d[wr_idx].attr = wr_attr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    // lowest matching slot wins if software ever loads a duplicate
    always_comb begin
        m_hit  = 1'b0;
        m_rpn  = '0;
        m_attr = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (ent_q[i].vld && (ent_q[i].vpn == lk_vpn)) begin
                m_hit  = 1'b1;
                m_rpn  = ent_q[i].rpn;
                m_attr = ent_q[i].attr;
            end
        end
    end
endmodule

// File: rtl/tw_tlb_walkregs.sv
module tw_tlb_walkregs
    import tw_tlb_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int IW    = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic             sr_we,
    input  logic [2:0]       sr_sel,
    input  logic [VA_W-1:0]  sr_wdata,
    output logic [VA_W-1:0]  sr_rdata,
    output logic             commit,
    output logic [IW-1:0]    vict_idx,
    output logic [VPN_W-1:0] held_vpn,
    output logic             pend
);
    typedef struct packed {
        logic [VPN_W-1:0]  mpage;
        logic              pend;
        logic [IW-1:0]     vict;
        logic [IW-1:0]     repl;
        logic [VPN_W-1:0]  l1base;
        logic [VPN_W-1:0]  l2base;
        logic [ATTR_W-1:0] l1attr;
        logic [VA_W-1:0]   scr;
    } st_t;

    st_t st_d, st_q;
    logic capture;

    assign capture = miss && !st_q.pend;
    assign commit  = sr_we && (sr_sel == SEL_RPAGE);

    always_comb begin
        st_d = st_q;
        if (commit) st_d.pend = 1'b0;
        if (capture) begin
            st_d.mpage = miss_vpn;
            st_d.pend  = 1'b1;
            st_d.vict  = st_q.repl;
            st_d.repl  = (st_q.repl == IW'(N_ENT - 1)) ? '0 : st_q.repl + 1'b1;
        end
        if (sr_we) begin
            case (sr_sel)
                SEL_L1PTR: st_d.l1base = sr_wdata[VA_W-1:PG_W];
                SEL_L2PTR: begin
                    st_d.l2base = sr_wdata[VA_W-1:PG_W];
                    st_d.l1attr = sr_wdata[ATTR_W-1:0];
                end
                SEL_SCR:   st_d.scr = sr_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        sr_rdata = '0;
        case (sr_sel)
            SEL_MPAGE: sr_rdata = {st_q.mpage, MISS_ATTR};
            SEL_CTRL: begin
                sr_rdata[27:16]  = st_q.l1attr;
                sr_rdata[IW-1:0] = st_q.vict;
            end
            SEL_L1PTR: sr_rdata = {st_q.l1base, st_q.mpage[VPN_W-1 -: L1_W], 2'b00};
            SEL_L2PTR: sr_rdata = {st_q.l2base, st_q.mpage[L2_W-1:0], 2'b00};
            SEL_SCR:   sr_rdata = st_q.scr;
            default:   sr_rdata = '0;
        endcase
    end

    assign vict_idx = st_q.vict;
    assign held_vpn = st_q.mpage;
    assign pend     = st_q.pend;
endmodule

// File: rtl/tw_tlb_assist.sv
module tw_tlb_assist
    import tw_tlb_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_valid,
    input  logic [31:0] lk_vaddr,
    output logic        lk_hit,
    output logic        lk_miss,
    output logic [31:0] lk_paddr,
    output logic [11:0] lk_attr,
    input  logic        sr_we,
    input  logic [2:0]  sr_sel,
    input  logic [31:0] sr_wdata,
    output logic [31:0] sr_rdata
);
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic              m_hit;
    logic [VPN_W-1:0]  m_rpn;
    logic [ATTR_W-1:0] m_attr;
    logic              commit_w;
    logic [IW-1:0]     vict_w;
    logic [VPN_W-1:0]  held_w;
    logic              pend_w;

    tw_tlb_cam #(.N_ENT(N_ENT), .IW(IW)) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_w),
        .wr_idx  (vict_w),
        .wr_vpn  (held_w),
        .wr_rpn  (sr_wdata[VA_W-1:PG_W]),
        .wr_attr (sr_wdata[ATTR_W-1:0]),
        .lk_vpn  (lk_vaddr[VA_W-1:PG_W]),
        .m_hit   (m_hit),
        .m_rpn   (m_rpn),
        .m_attr  (m_attr)
    );

    assign lk_hit   = lk_valid && m_hit;
    assign lk_miss  = lk_valid && !m_hit;
    assign lk_paddr = lk_hit ? {m_rpn, lk_vaddr[PG_W-1:0]} : '0;
    assign lk_attr  = lk_hit ? m_attr : '0;

    tw_tlb_walkregs #(.N_ENT(N_ENT), .IW(IW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .miss     (lk_miss),
        .miss_vpn (lk_vaddr[VA_W-1:PG_W]),
        .sr_we    (sr_we),
        .sr_sel   (sr_sel),
        .sr_wdata (sr_wdata),
        .sr_rdata (sr_rdata),
        .commit   (commit_w),
        .vict_idx (vict_w),
        .held_vpn (held_w),
        .pend     (pend_w)
    );
endmodule

// File: rtl/tw_tlb_assist_chk.sv
module tw_tlb_assist_chk #(
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_valid,
    input logic          lk_hit,
    input logic          lk_miss,
    input logic          commit,
    input logic          pend,
    input logic [IW-1:0] vict,
    input logic [19:0]   held
);
    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss && !pend) |=> pend);

    p_hold_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_miss && !pend) |=> $stable(vict));

    p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> ($stable(held) && $stable(vict)));

    p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !(lk_miss && !pend)) |=> !pend);
endmodule

bind tw_tlb_assist tw_tlb_assist_chk #(.IW(IW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .commit   (commit_w),
    .pend     (pend_w),
    .vict     (vict_w),
    .held     (held_w)
);

// File: tb/test_tw_tlb_assist.sv
module test_tw_tlb_assist;
    localparam logic [2:0] S_MP = 3'd0, S_CT = 3'd1, S_L1 = 3'd2, S_L2 = 3'd3,
                           S_RP = 3'd4, S_SC = 3'd5;
    localparam logic [31:0] L1BASE = 32'h0012_3000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 1'b0, sr_we = 1'b0;
    logic [31:0] lk_vaddr = '0, sr_wdata = '0;
    logic [2:0]  sr_sel = '0;
    logic lk_hit, lk_miss;
    logic [31:0] lk_paddr, sr_rdata;
    logic [11:0] lk_attr;
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    tw_tlb_assist i_tw_tlb_assist (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_attr(lk_attr),
        .sr_we(sr_we), .sr_sel(sr_sel), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata)
    );

    function automatic logic [31:0] va(input int i);
        return {10'(i * 3 + 1), 10'(i * 5 + 2), 12'(i * 17 + 3)};
    endfunction
    function automatic logic [19:0] rp(input int i);
        return 20'hA0000 + 20'(i * 257);
    endfunction
    function automatic logic [19:0] l2b(input int i);
        return 20'h30000 + 20'(i);
    endfunction
    function automatic logic [11:0] l1a(input int i);
        return 12'h800 + 12'(i);
    endfunction
    function automatic logic [11:0] pat(input int i);
        return 12'h040 + 12'(i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] a, output logic h, output logic m,
                        output logic [31:0] pa, output logic [11:0] at);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = a;
        #1;
        h = lk_hit; m = lk_miss; pa = lk_paddr; at = lk_attr;
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        sr_sel = s;
        #1 d = sr_rdata;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        sr_sel = s; sr_wdata = d; sr_we = 1'b1;
        @(posedge clk);
        #1 sr_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // full handler sequence: miss, pointers, commit entry built from index i
    task automatic refill(input int i, input int slot);
        logic h, m; logic [31:0] pa, d; logic [11:0] at;
        logic [31:0] a;
        a = va(i);
        look(a, h, m, pa, at);
        chk("R2 miss flag", {31'd0, m}, 32'd1);
        chk("R1 paddr zero on miss", pa, 32'd0);
        rd(S_MP, d);
        chk("R3 miss page", d, {a[31:12], 12'h001});
        rd(S_CT, d);
        chk("R4 victim index", {29'd0, d[2:0]}, 32'(slot));
        rd(S_L1, d);
        chk("R6 level-one pointer", d, {L1BASE[31:12], a[31:22], 2'b00});
        wr(S_L2, {l2b(i), l1a(i)});
        rd(S_CT, d);
        chk("R7 level-one attrs", {20'd0, d[27:16]}, {20'd0, l1a(i)});
        rd(S_L2, d);
        chk("R7 level-two pointer", d, {l2b(i), a[21:12], 2'b00});
        wr(S_RP, {rp(i), pat(i)});
        look(a, h, m, pa, at);
        chk("R8 committed hit", {31'd0, h}, 32'd1);
        chk("R8 committed paddr", pa, {rp(i), a[11:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic h, m; logic [31:0] pa, d, a; logic [11:0] at;
        do_reset();
        rd(S_CT, d);
        chk("R10 index after reset", {29'd0, d[2:0]}, 32'd0);
        look(va(3), h, m, pa, at);
        chk("R10 empty after reset", {30'd0, h, m}, 32'd1);
        do_reset();
        wr(S_L1, L1BASE);
        for (int i = 0; i < 8; i++) refill(i, i);
        // R1 sweep over all slots with fresh offsets
        for (int i = 0; i < 8; i++) begin
            a = {va(i)[31:12], 12'(12'hFFF - i * 9)};
            look(a, h, m, pa, at);
            chk("R1 hit", {30'd0, h, m}, 32'd2);
            chk("R1 paddr", pa, {rp(i), a[11:0]});
            chk("R1 attr", {20'd0, at}, {20'd0, pat(i)});
        end
        // R4 wrap: ninth miss replaces slot 0
        refill(8, 0);
        look(va(0), h, m, pa, at);
        chk("R4 slot 0 replaced", {31'd0, m}, 32'd1);
        // R5: second miss while refill for va(0) is pending
        look(va(9), h, m, pa, at);
        chk("R5 miss still flagged", {31'd0, m}, 32'd1);
        rd(S_MP, d);
        chk("R5 miss page locked", d, {va(0)[31:12], 12'h001});
        rd(S_CT, d);
        chk("R5 index locked", {29'd0, d[2:0]}, 32'd1);
        look(va(1), h, m, pa, at);
        chk("R5 slot 1 intact", pa, {rp(1), va(1)[11:0]});
        wr(S_L2, {l2b(0), l1a(0)});
        wr(S_RP, {rp(0), pat(0)});
        look(va(0), h, m, pa, at);
        chk("R8 refilled into slot 1", pa, {rp(0), va(0)[11:0]});
        look(va(1), h, m, pa, at);
        chk("R8 slot 1 overwritten", {31'd0, m}, 32'd1);
        // R9 scratch
        wr(S_SC, 32'hC0DE_5A5A);
        rd(S_SC, d);
        chk("R9 scratch readback", d, 32'hC0DE_5A5A);
        rd(S_MP, d);
        chk("R9 no side effect on miss page", d, {va(1)[31:12], 12'h001});
        look(va(2), h, m, pa, at);
        chk("R9 no side effect on entries", pa, {rp(2), va(2)[11:0]});
        // R11 ignored writes and zero reads
        wr(S_MP, 32'hFFFF_FFFF);
        rd(S_MP, d);
        chk("R11 miss page write ignored", d, {va(1)[31:12], 12'h001});
        wr(S_CT, 32'hFFFF_FFFF);
        rd(S_CT, d);
        chk("R11 control write ignored", d, {4'd0, l1a(0), 13'd0, 3'd2});
        wr(3'd7, 32'h1234_5678);
        rd(3'd7, d);
        chk("R11 select 7 reads zero", d, 32'd0);
        rd(3'd6, d);
        chk("R11 select 6 reads zero", d, 32'd0);
        rd(S_RP, d);
        chk("R11 select 4 reads zero", d, 32'd0);
        rd(S_SC, d);
        chk("R11 scratch untouched", d, 32'hC0DE_5A5A);
        // R10 reset mid-run
        do_reset();
        rd(S_CT, d);
        chk("R10 index cleared", {29'd0, d[2:0]}, 32'd0);
        look(va(2), h, m, pa, at);
        chk("R10 entries invalidated", {30'd0, h, m}, 32'd1);
        look(32'd0, h, m, pa, at);
        @(negedge clk);
        #1 chk("R2 idle outputs low", {30'd0, lk_hit, lk_miss}, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule